// File: doc/BRIEF.md
# Disk Interface Reset Sequencer

This block drives the two reset mechanisms of a parallel disk interface and keeps their timing legal without help from software. When the power-good indication rises it holds the active-low interface reset line low for a full hardware-reset interval. It then releases the line and waits for software-reset requests. Each request produces one SRST pulse: the bit is set, held for the minimum spacing time, cleared, and then kept clear for the same minimum time before another set is allowed.

All intervals are counted in clock cycles. The counts come from a clock-frequency parameter and are rounded up, so the real time is never shorter than the rule. A request is never dropped for being early. If it arrives while the drive reports busy, during an SRST pulse, or during the spacing that follows one, it is latched and carried out once it is allowed. The ready flag tells the requesting logic when no reset activity is running or waiting.

Top module: `disk_rst_seq`

## Requirements
- R1: While the block's own reset `rst_n` is low, and in the first cycle after it is released, `ata_reset_n_o` is 0, `srst_o` is 0 and `ready_o` is 0.
- R2: At every clock edge that samples `pwr_good_i` low, the sequencer enters the powered-off state. From that edge on, `ata_reset_n_o` is 0 and `srst_o` is 0. Any request pending at that edge, or arriving while power is off, is discarded.
- R3: Let HRST_CYC be 25 µs times the clock frequency, rounded up and never less than the rounded-up 20 ns count. `ata_reset_n_o` stays 0 after the first edge that samples `pwr_good_i` high, and through the next HRST_CYC-1 edges. It goes to 1 at the edge HRST_CYC edges after that first edge.
- R4: Let SP_CYC be 5 µs times the clock frequency, rounded up. Once set, `srst_o` stays 1 for exactly SP_CYC cycles. It then stays 0 for exactly SP_CYC cycles before the sequencer is idle again.
- R5: `srst_o` is set only at an edge that samples `dev_bsy_i` low. A request seen while busy waits and starts at the first edge that samples busy low. `dev_bsy_i` does not delay the clearing of `srst_o`.
- R6: A request is a one-cycle high pulse on `sw_rst_req_i`. It is captured at the edge that samples it, and the earliest SRST set is one edge later. A request that arrives during a hardware reset, an SRST pulse or its spacing interval is carried out after that activity ends. Several such requests merge into one SRST pulse.
- R7: `ready_o` is 1 only when the sequencer is idle with `ata_reset_n_o` high, `srst_o` low and no request pending.
- R8: If power-good drops while `srst_o` is 1, `srst_o` and `ata_reset_n_o` are both 0 after the next edge. A complete hardware-reset interval (R3) follows when power returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock with the period given by the CLK_HZ parameter |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| pwr_good_i | input | 1 | Supply is within tolerance when 1 |
| sw_rst_req_i | input | 1 | One-cycle pulse requesting a software reset |
| dev_bsy_i | input | 1 | Busy bit from the device status register |
| ata_reset_n_o | output | 1 | Active-low hardware reset line to the drive |
| srst_o | output | 1 | Value to drive into the SRST bit of the device control register |
| ready_o | output | 1 | No reset running and no request waiting |

## Verification
Most faults in this block show up as a wrong interval length. A timer loaded with the wrong count, or a state that exits one cycle early, moves an edge of `ata_reset_n_o` or `srst_o`. That shift appears at the first boundary after the state is entered: within HRST_CYC or SP_CYC cycles. A lost or duplicated pending request shows as a missing or extra SRST pulse, or as `ready_o` rising early. This is visible within about two SP_CYC intervals of the request. A busy interlock that is bypassed raises `srst_o` one edge after a request, even with `dev_bsy_i` held high.

// File: rtl/disk_rst_pkg.sv
`timescale 1ns/1ps
package disk_rst_pkg;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,  // supply not good, line held in reset
    ST_HRST     = 3'd1,  // hardware reset interval running
    ST_IDLE     = 3'd2,  // free to accept a software reset
    ST_SRST_ON  = 3'd3,  // SRST bit held at 1
    ST_SRST_GAP = 3'd4   // SRST bit back at 0, spacing interval
  } drs_state_e;

  // Cycles needed to cover ns nanoseconds at hz, rounded up, at least one.
  function automatic int unsigned ns_to_cycles(longint unsigned ns,
                                               longint unsigned hz);
    longint unsigned prod;
    longint unsigned cyc;
    prod = ns * hz;
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc == 64'd0) cyc = 64'd1;
    return 32'(cyc);
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drs_timer.sv
`timescale 1ns/1ps
module drs_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/drs_req_hold.sv
`timescale 1ns/1ps
module drs_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic take,
  input  logic flush,
  output logic pend
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (flush) pend_q <= 1'b0;
    else            pend_q <= req | (pend_q & ~take);
  end

  assign pend = pend_q;

endmodule

// File: rtl/disk_rst_seq.sv
`timescale 1ns/1ps
module disk_rst_seq
  import disk_rst_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned     HRST_NS      = 25_000,
  parameter int unsigned     SPACE_NS     = 5_000,
  parameter int unsigned     MIN_PULSE_NS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good_i,
  input  logic sw_rst_req_i,
  input  logic dev_bsy_i,
  output logic ata_reset_n_o,
  output logic srst_o,
  output logic ready_o
);

  localparam int unsigned HRST_RAW = ns_to_cycles(longint'(HRST_NS), CLK_HZ);
  localparam int unsigned MINP_CYC = ns_to_cycles(longint'(MIN_PULSE_NS), CLK_HZ);
  localparam int unsigned HRST_CYC = max_u(HRST_RAW, MINP_CYC);
  localparam int unsigned SP_CYC   = ns_to_cycles(longint'(SPACE_NS), CLK_HZ);
  localparam int unsigned MAX_CYC  = max_u(HRST_CYC, SP_CYC);
  localparam int          CNT_W    = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] HRST_LD = CNT_W'(HRST_CYC - 1);
  localparam logic [CNT_W-1:0] SP_LD   = CNT_W'(SP_CYC - 1);

  drs_state_e       st_q, st_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             pend;

  // named internal events
  logic launch_w;      // SRST set is allowed and requested this cycle
  logic hrst_done_w;   // hardware reset interval ends at this edge
  logic space_done_w;  // current SRST phase ends at this edge
  logic off_w;         // sequencer sits in the powered-off state

  assign off_w        = (st_q == ST_OFF);
  assign launch_w     = (st_q == ST_IDLE) && pend && !dev_bsy_i;
  assign hrst_done_w  = (st_q == ST_HRST) && tmr_expired;
  assign space_done_w = ((st_q == ST_SRST_ON) || (st_q == ST_SRST_GAP)) && tmr_expired;

  drs_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  drs_req_hold u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (sw_rst_req_i),
    .take  (launch_w),
    .flush (off_w),
    .pend  (pend)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (!pwr_good_i) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_d     = ST_HRST;
          tmr_load = 1'b1;
          tmr_val  = HRST_LD;
        end
        ST_HRST: begin
          if (hrst_done_w) st_d = ST_IDLE;
        end
        ST_IDLE: begin
          if (launch_w) begin
            st_d     = ST_SRST_ON;
            tmr_load = 1'b1;
            tmr_val  = SP_LD;
          end
        end
        ST_SRST_ON: begin
          if (space_done_w) begin
            st_d     = ST_SRST_GAP;
            tmr_load = 1'b1;
            tmr_val  = SP_LD;
          end
        end
        ST_SRST_GAP: begin
          if (space_done_w) st_d = ST_IDLE;
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign ata_reset_n_o = !((st_q == ST_OFF) || (st_q == ST_HRST));
  assign srst_o        = (st_q == ST_SRST_ON);
  assign ready_o       = (st_q == ST_IDLE) && !pend;

endmodule

// File: rtl/disk_rst_seq_chk.sv
`timescale 1ns/1ps
module disk_rst_seq_chk #(
  parameter int unsigned HRST_CYC = 2500,
  parameter int unsigned SP_CYC   = 500
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_good_i,
  input logic dev_bsy_i,
  input logic ata_reset_n_o,
  input logic srst_o,
  input logic ready_o
);

  int unsigned rst_lo_cnt, srst_hi_cnt, srst_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_lo_cnt  <= 0;
      srst_hi_cnt <= 0;
      srst_lo_cnt <= 0;
    end else begin
      rst_lo_cnt  <= ata_reset_n_o ? 0 : ((rst_lo_cnt  == 32'hFFFF_FFFF) ? rst_lo_cnt  : rst_lo_cnt  + 1);
      srst_hi_cnt <= !srst_o       ? 0 : ((srst_hi_cnt == 32'hFFFF_FFFF) ? srst_hi_cnt : srst_hi_cnt + 1);
      srst_lo_cnt <= srst_o        ? 0 : ((srst_lo_cnt == 32'hFFFF_FFFF) ? srst_lo_cnt : srst_lo_cnt + 1);
    end
  end

  p_power_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good_i |=> (!ata_reset_n_o && !srst_o));

  p_hrst_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ata_reset_n_o) |-> (rst_lo_cnt >= HRST_CYC));

  p_srst_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(srst_o) && ata_reset_n_o) |-> (srst_hi_cnt >= SP_CYC));

  p_srst_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_o) |-> (srst_lo_cnt >= SP_CYC));

  p_no_set_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_o) |-> !$past(dev_bsy_i));

  p_ready_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (ata_reset_n_o && !srst_o));

  p_srst_needs_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_o |-> ata_reset_n_o);

endmodule

bind disk_rst_seq disk_rst_seq_chk #(.HRST_CYC(HRST_CYC), .SP_CYC(SP_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pwr_good_i    (pwr_good_i),
  .dev_bsy_i     (dev_bsy_i),
  .ata_reset_n_o (ata_reset_n_o),
  .srst_o        (srst_o),
  .ready_o       (ready_o)
);

// File: tb/disk_rst_seq_tb_top.sv
`timescale 1ns/1ps
module disk_rst_seq_tb_top;

  localparam int unsigned CLK_PERIOD = 100;  // ns
  localparam int unsigned H = (25000 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int unsigned S = (5000 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic req = 1'b0;
  logic bsy = 1'b0;
  logic rst_line_n, srst, ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  disk_rst_seq #(.CLK_HZ(64'd1_000_000_000 / CLK_PERIOD)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_good_i    (pwr_good),
    .sw_rst_req_i  (req),
    .dev_bsy_i     (bsy),
    .ata_reset_n_o (rst_line_n),
    .srst_o        (srst),
    .ready_o       (ready)
  );

  typedef struct packed {
    logic        pwr;
    logic        rq;
    logic        by;
    int unsigned ticks;
    logic        e_rn;
    logic        e_sr;
    logic        e_rd;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1,     1'b0, 1'b0, 1'b0, 8'd3},  // R3 first edge with power good
    '{1'b1, 1'b0, 1'b0, H - 1, 1'b0, 1'b0, 1'b0, 8'd3},  // R3 last low edge
    '{1'b1, 1'b0, 1'b0, 1,     1'b1, 1'b0, 1'b1, 8'd3},  // R3 release
    '{1'b1, 1'b1, 1'b0, 1,     1'b1, 1'b0, 1'b0, 8'd7},  // R7 pending clears ready
    '{1'b1, 1'b0, 1'b0, 1,     1'b1, 1'b1, 1'b0, 8'd4},  // R4 set
    '{1'b1, 1'b0, 1'b0, S - 1, 1'b1, 1'b1, 1'b0, 8'd4},  // R4 still set
    '{1'b1, 1'b0, 1'b0, 1,     1'b1, 1'b0, 1'b0, 8'd4},  // R4 cleared
    '{1'b1, 1'b0, 1'b0, S - 1, 1'b1, 1'b0, 1'b0, 8'd4},  // R4 still spacing
    '{1'b1, 1'b0, 1'b0, 1,     1'b1, 1'b0, 1'b1, 8'd4},  // R4 idle
    '{1'b1, 1'b1, 1'b1, 3,     1'b1, 1'b0, 1'b0, 8'd5},  // R5 busy blocks
    '{1'b1, 1'b0, 1'b1, 20,    1'b1, 1'b0, 1'b0, 8'd5},  // R5 still blocked
    '{1'b1, 1'b0, 1'b0, 1,     1'b1, 1'b1, 1'b0, 8'd5},  // R5 starts when busy low
    '{1'b1, 1'b0, 1'b1, S - 1, 1'b1, 1'b1, 1'b0, 8'd5},  // R5 busy during pulse
    '{1'b1, 1'b0, 1'b1, 1,     1'b1, 1'b0, 1'b0, 8'd5},  // R5 clear not blocked
    '{1'b1, 1'b1, 1'b0, 1,     1'b1, 1'b0, 1'b0, 8'd6},  // R6 request in spacing
    '{1'b1, 1'b0, 1'b0, S - 2, 1'b1, 1'b0, 1'b0, 8'd6},  // R6 held
    '{1'b1, 1'b0, 1'b0, 1,     1'b1, 1'b0, 1'b0, 8'd6},  // R6 idle, not yet set
    '{1'b1, 1'b0, 1'b0, 1,     1'b1, 1'b1, 1'b0, 8'd6},  // R6 carried out
    '{1'b1, 1'b0, 1'b0, S,     1'b1, 1'b0, 1'b0, 8'd6},  // R6 pulse over
    '{1'b1, 1'b0, 1'b0, S,     1'b1, 1'b0, 1'b1, 8'd6},  // R6 no extra pulse
    '{1'b1, 1'b1, 1'b0, 1,     1'b1, 1'b0, 1'b0, 8'd7},  // R7
    '{1'b1, 1'b0, 1'b0, 1,     1'b1, 1'b1, 1'b0, 8'd4},  // R4 set again
    '{1'b0, 1'b0, 1'b0, 1,     1'b0, 1'b0, 1'b0, 8'd8},  // R8 power loss mid pulse
    '{1'b0, 1'b1, 1'b0, 5,     1'b0, 1'b0, 1'b0, 8'd2},  // R2 off, request ignored
    '{1'b1, 1'b0, 1'b0, H,     1'b0, 1'b0, 1'b0, 8'd3},  // R3 full interval again
    '{1'b1, 1'b0, 1'b0, 1,     1'b1, 1'b0, 1'b1, 8'd2}   // R2 nothing pending
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s {reset_n,srst,ready} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int high_cnt;
    @(negedge clk);
    check("R1 in reset", {rst_line_n, srst, ready}, 3'b000);
    tick();
    rst_n = 1'b1;
    tick();
    check("R1 after release", {rst_line_n, srst, ready}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      pwr_good = TBL[i].pwr;
      bsy      = TBL[i].by;
      req      = TBL[i].rq;
      tick();
      req = 1'b0;
      for (int k = 1; k < int'(TBL[i].ticks); k++) tick();
      check($sformatf("R%0d vector %0d", TBL[i].tag, i),
            {rst_line_n, srst, ready}, {TBL[i].e_rn, TBL[i].e_sr, TBL[i].e_rd});
    end

    // R1: block reset during an SRST pulse
    req = 1'b1; tick(); req = 1'b0; tick();
    check("R6 set before reset", {rst_line_n, srst, ready}, 3'b110);
    rst_n = 1'b0;
    #1;
    check("R1 mid-pulse reset", {rst_line_n, srst, ready}, 3'b000);
    tick(); tick();
    rst_n = 1'b1;
    for (int k = 0; k < int'(H) + 1; k++) tick();
    check("R3 after block reset", {rst_line_n, srst, ready}, 3'b101);

    // R6: several requests during one pulse merge into a single further pulse
    high_cnt = 0;
    for (int i = 0; i < 6 * int'(S); i++) begin
      req = (i == 0 || i == 5 || i == 15 || i == 25);
      tick();
      req = 1'b0;
      if (srst) high_cnt++;
    end
    check("R6 merged pulses high cycles", {1'b0, (high_cnt == 2 * int'(S)), 1'b0}, 3'b010);
    if (high_cnt != 2 * int'(S))
      $display("FAIL R6 high cycles actual=%0d expected=%0d", high_cnt, 2 * S);
    check("R7 ready after merge", {rst_line_n, srst, ready}, 3'b101);

    // R5: busy held, request waits, then starts exactly one edge after busy low
    bsy = 1'b1; req = 1'b1; tick(); req = 1'b0;
    for (int k = 0; k < 7; k++) tick();
    check("R5 blocked long", {rst_line_n, srst, ready}, 3'b100);
    bsy = 1'b0; tick();
    check("R5 release start", {rst_line_n, srst, ready}, 3'b110);

    finish_run();
  end

endmodule